// File: doc/BRIEF.md
# Windowed Address Decoder with Default Target

This block turns a transaction address into a destination target ID. Software programs a set of address windows through a small register port. Each window has an enable bit, a target ID, a write-secure attribute, and a low and a high bound. Both bounds are kept at 1 MB granularity, and the high bound is inclusive. A request that falls in no enabled window is sent to a programmable default target. This means every request gets a destination.

Each request carries an address, a write flag and a secure flag. The block registers its result, so the answer appears one cycle after the request. The answer has three parts:
- a hit flag, set when an enabled window matched;
- a route flag, set when the target output is usable;
- a violation flag, set when a non-secure write hits a write-protected window.

A violation suppresses the route and forces the target output to zero. Window 0 leaves reset already enabled and mapping the internal configuration region, so that region can be reached before any programming.

The decode result is held in a four-valued result state: `RES_IDLE`, `RES_MISS`, `RES_HIT` and `RES_BLOCK`. Each cycle the next state comes from the incoming request:
- `RES_IDLE` when no request arrives;
- `RES_BLOCK` when a matching window is write-secure and the request is a non-secure write;
- `RES_HIT` for any other match;
- `RES_MISS` when no enabled window matches.

Any state can move to any other state on the next clock.

Top module: `addr_window_decoder`

## Requirements
- R1: Reset state:
  - window 0 is enabled, covers granules CFG_LO_G..CFG_HI_G and targets CFG_TID;
  - all other windows are disabled and zero;
  - the default target is DEF_TID;
  - no response is valid.
- R2: `rsp_valid` is high exactly one cycle after `req_valid`. When `rsp_valid` is low, hit, violation and route are all low.
- R3: The low register sits at window offset +0x8 and the high register at +0xC. Each keeps address bits [47:20] in register bits [31:4]. Register bits [3:0] are ignored on write and read as zero.
- R4: The high bound is inclusive. Any address inside the high granule hits the window, and the next granule does not.
- R5: The control register sits at window offset +0x0. Bit 0 is the enable and bits [11:8] hold the target ID, which is returned on `rsp_target` on a hit.
- R6: A request that matches no enabled window gives hit=0, route=1, and the target held in the default register. The default register sits at offset 0x100, with the target in bits [3:0].
- R7: When several enabled windows match, the lowest-numbered window supplies the target.
- R8: Clearing the enable bit stops a window from matching and leaves its target and bounds unchanged. Setting the bit again restores the same mapping.
- R9: The security register sits at window offset +0x4. Bit 0 is read-secure and bit 1 is write-secure. The two bits are written and read back independently.
- R10: A non-secure write that hits a window with write-secure set gives violation=1, hit=1, route=0 and target 0. Secure writes and all reads to that window route normally.
- R11: Window n's registers sit at base 0x10*n. A register write is seen by a request issued in the cycle after the write.
- R12: Read data appears on `reg_rdata` one cycle after a read request. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 48 | Transaction address |
| req_write | input | 1 | Request is a write |
| req_secure | input | 1 | Request is secure |
| rsp_valid | output | 1 | Decode result valid |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_viol | output | 1 | Write-secure violation |
| rsp_route | output | 1 | Target is usable |
| rsp_target | output | 4 | Destination target ID |

## Verification
The bench probes several bound cases:
- the first and last byte of a window's high granule, where an exclusive compare would drop the last granule;
- the granule just above the high bound, where an off-by-one limit would still hit;
- overlapping windows, where a highest-index pick would return the wrong target;
- an address with only a high bit set, which catches a truncated compare.

On the security side, it checks that only non-secure writes are blocked. A design that also blocked reads or secure writes, or that kept routing on a violation, would be reported.

It disables a window and reads back the window's registers. It also writes then requests on back-to-back cycles. These catch a design that cleared fields on disable or applied writes late.

Finally, it writes and reads unmapped offsets to expose address aliasing.

// File: rtl/awd_pkg.sv
`timescale 1ns/1ps
package awd_pkg;
    // Result state of the registered decode
    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_MISS  = 2'd1,
        RES_HIT   = 2'd2,
        RES_BLOCK = 2'd3
    } res_e;

    // Register slot inside a window, selected by offset bits [3:2]
    localparam logic [1:0] SLOT_CTRL = 2'd0;
    localparam logic [1:0] SLOT_SEC  = 2'd1;
    localparam logic [1:0] SLOT_LO   = 2'd2;
    localparam logic [1:0] SLOT_HI   = 2'd3;

    localparam int DEF_OFFSET   = 'h100;
    localparam int WIN_STRIDE   = 'h10;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_TID_LSB = 8;
    localparam int SEC_RD_BIT   = 0;
    localparam int SEC_WR_BIT   = 1;
    localparam int BOUND_LSB    = 4;
endpackage

// File: rtl/awd_regs.sv
`timescale 1ns/1ps
module awd_regs
    import awd_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int GW    = 28,
    parameter int TID_W = 4,
    parameter int RAW   = 9,
    parameter logic [GW-1:0]    CFG_LO_G = '0,
    parameter logic [GW-1:0]    CFG_HI_G = '0,
    parameter logic [TID_W-1:0] CFG_TID  = '0,
    parameter logic [TID_W-1:0] DEF_TID  = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_valid,
    input  logic                        reg_write,
    input  logic [RAW-1:0]              reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic [NWIN-1:0]             win_en,
    output logic [NWIN-1:0]             win_wsec,
    output logic [NWIN-1:0]             win_rsec,
    output logic [NWIN-1:0][TID_W-1:0]  win_tid,
    output logic [NWIN-1:0][GW-1:0]     win_lo,
    output logic [NWIN-1:0][GW-1:0]     win_hi,
    output logic [TID_W-1:0]            def_tid
);
    localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int WIN_SPAN = NWIN * WIN_STRIDE;
    localparam logic [RAW-1:0] DEF_A = DEF_OFFSET[RAW-1:0];

    logic           in_win;
    logic [1:0]     slot;
    logic [IDXW-1:0] ridx;
    logic [31:0]    rd_d;

    assign in_win = (int'(reg_addr) < WIN_SPAN);
    assign slot   = reg_addr[3:2];
    assign ridx   = reg_addr[IDXW+3:4];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic            RST_EN  = (w == 0) ? 1'b1 : 1'b0;
        localparam logic [TID_W-1:0] RST_TID = (w == 0) ? CFG_TID : '0;
        localparam logic [GW-1:0]   RST_LO  = (w == 0) ? CFG_LO_G : '0;
        localparam logic [GW-1:0]   RST_HI  = (w == 0) ? CFG_HI_G : '0;

        logic             en_q, wsec_q, rsec_q, sel;
        logic [TID_W-1:0] tid_q;
        logic [GW-1:0]    lo_q, hi_q;

        assign sel = reg_valid && reg_write && in_win
                     && (reg_addr[RAW-1:4] == (RAW-4)'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q   <= RST_EN;
                tid_q  <= RST_TID;
                lo_q   <= RST_LO;
                hi_q   <= RST_HI;
                wsec_q <= 1'b0;
                rsec_q <= 1'b0;
            end else if (sel) begin
                case (slot)
                    SLOT_CTRL: begin
                        en_q  <= reg_wdata[CTRL_EN_BIT];
                        tid_q <= reg_wdata[CTRL_TID_LSB +: TID_W];
                    end
                    SLOT_SEC: begin
                        rsec_q <= reg_wdata[SEC_RD_BIT];
                        wsec_q <= reg_wdata[SEC_WR_BIT];
                    end
                    SLOT_LO: lo_q <= reg_wdata[BOUND_LSB +: GW];
                    SLOT_HI: hi_q <= reg_wdata[BOUND_LSB +: GW];
                endcase
            end
        end

        assign win_en[w]   = en_q;
        assign win_wsec[w] = wsec_q;
        assign win_rsec[w] = rsec_q;
        assign win_tid[w]  = tid_q;
        assign win_lo[w]   = lo_q;
        assign win_hi[w]   = hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_tid <= DEF_TID;
        end else if (reg_valid && reg_write && (reg_addr == DEF_A)) begin
            def_tid <= reg_wdata[TID_W-1:0];
        end
    end

    always_comb begin
        rd_d = '0;
        if (in_win) begin
            case (slot)
                SLOT_CTRL: begin
                    rd_d[CTRL_EN_BIT]              = win_en[ridx];
                    rd_d[CTRL_TID_LSB +: TID_W]    = win_tid[ridx];
                end
                SLOT_SEC: begin
                    rd_d[SEC_RD_BIT] = win_rsec[ridx];
                    rd_d[SEC_WR_BIT] = win_wsec[ridx];
                end
                SLOT_LO: rd_d[BOUND_LSB +: GW] = win_lo[ridx];
                SLOT_HI: rd_d[BOUND_LSB +: GW] = win_hi[ridx];
            endcase
        end else if (reg_addr == DEF_A) begin
            rd_d[TID_W-1:0] = def_tid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_valid && !reg_write) begin
            reg_rdata <= rd_d;
        end
    end
endmodule

// File: rtl/awd_match.sv
`timescale 1ns/1ps
module awd_match #(
    parameter int GW = 28
) (
    input  logic          en,
    input  logic [GW-1:0] lo,
    input  logic [GW-1:0] hi,
    input  logic [GW-1:0] gran,
    output logic          hit
);
    // Inclusive on both ends: the high register names the last granule
    assign hit = en && (gran >= lo) && (gran <= hi);
endmodule

// File: rtl/awd_pick.sv
`timescale 1ns/1ps
module awd_pick #(
    parameter int NWIN  = 8,
    parameter int TID_W = 4
) (
    input  logic [NWIN-1:0]            hits,
    input  logic [NWIN-1:0][TID_W-1:0] tids,
    input  logic [NWIN-1:0]            wsecs,
    output logic                       any,
    output logic [TID_W-1:0]           tid,
    output logic                       wsec
);
    // Walk downward so the lowest-numbered match is written last
    always_comb begin
        tid  = '0;
        wsec = 1'b0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                tid  = tids[i];
                wsec = wsecs[i];
            end
        end
    end

    assign any = |hits;
endmodule

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NWIN     = 8,
    parameter int ADDR_W   = 48,
    parameter int GRAN_LSB = 20,
    parameter int TID_W    = 4,
    parameter int RAW      = 9,
    parameter logic [ADDR_W-GRAN_LSB-1:0] CFG_LO_G = 'h0000F00,
    parameter logic [ADDR_W-GRAN_LSB-1:0] CFG_HI_G = 'h0000F0F,
    parameter logic [TID_W-1:0]           CFG_TID  = 4'hE,
    parameter logic [TID_W-1:0]           DEF_TID  = 4'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_viol,
    output logic              rsp_route,
    output logic [TID_W-1:0]  rsp_target
);
    localparam int GW = ADDR_W - GRAN_LSB;

    logic [NWIN-1:0]            win_en, win_wsec, win_rsec, win_hit;
    logic [NWIN-1:0][TID_W-1:0] win_tid;
    logic [NWIN-1:0][GW-1:0]    win_lo, win_hi;
    logic [TID_W-1:0]           def_tid;
    logic [GW-1:0]              gran;
    logic                       any_hit, sel_wsec;
    logic [TID_W-1:0]           sel_tid;

    res_e             res_d, res_q;
    logic [TID_W-1:0] tid_d, tid_q;

    awd_regs #(
        .NWIN(NWIN), .GW(GW), .TID_W(TID_W), .RAW(RAW),
        .CFG_LO_G(CFG_LO_G), .CFG_HI_G(CFG_HI_G),
        .CFG_TID(CFG_TID), .DEF_TID(DEF_TID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_en(win_en), .win_wsec(win_wsec), .win_rsec(win_rsec),
        .win_tid(win_tid), .win_lo(win_lo), .win_hi(win_hi),
        .def_tid(def_tid)
    );

    assign gran = req_addr[ADDR_W-1:GRAN_LSB];

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        awd_match #(.GW(GW)) u_match (
            .en(win_en[w]), .lo(win_lo[w]), .hi(win_hi[w]),
            .gran(gran), .hit(win_hit[w])
        );
    end

    awd_pick #(.NWIN(NWIN), .TID_W(TID_W)) u_pick (
        .hits(win_hit), .tids(win_tid), .wsecs(win_wsec),
        .any(any_hit), .tid(sel_tid), .wsec(sel_wsec)
    );

    // Next result state
    always_comb begin
        tid_d = any_hit ? sel_tid : def_tid;
        if (!req_valid) begin
            res_d = RES_IDLE;
        end else if (any_hit && sel_wsec && req_write && !req_secure) begin
            res_d = RES_BLOCK;
        end else if (any_hit) begin
            res_d = RES_HIT;
        end else begin
            res_d = RES_MISS;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_IDLE;
            tid_q <= '0;
        end else begin
            res_q <= res_d;
            tid_q <= tid_d;
        end
    end

    // Outputs per state
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_viol   = 1'b0;
        rsp_route  = 1'b0;
        rsp_target = '0;
        unique case (res_q)
            RES_IDLE: ;
            RES_MISS: begin
                rsp_valid  = 1'b1;
                rsp_route  = 1'b1;
                rsp_target = tid_q;
            end
            RES_HIT: begin
                rsp_valid  = 1'b1;
                rsp_hit    = 1'b1;
                rsp_route  = 1'b1;
                rsp_target = tid_q;
            end
            RES_BLOCK: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_viol  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/awd_chk.sv
`timescale 1ns/1ps
module awd_chk #(
    parameter int RAW = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_write,
    input logic           req_secure,
    input logic           reg_valid,
    input logic           reg_write,
    input logic [RAW-1:0] reg_addr,
    input logic [31:0]    reg_rdata,
    input logic           rsp_valid,
    input logic           rsp_hit,
    input logic           rsp_viol,
    input logic           rsp_route
);
    // R2: response exactly one cycle after request
    p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R2: quiet outputs with no response
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_viol && !rsp_route));

    // R10: violation only from a non-secure write, and never routed
    p_viol_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> ($past(req_write) && !$past(req_secure)));

    p_viol_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> (rsp_hit && !rsp_route));

    // R6: any valid non-violating response is routed
    p_always_routed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_viol) |-> rsp_route);

    // R3: bound registers read back with a zero low nibble
    p_bound_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && !reg_addr[RAW-1] && reg_addr[3])
        |=> (reg_rdata[3:0] == 4'h0));
endmodule

bind addr_window_decoder awd_chk #(.RAW(RAW)) u_awd_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_viol(rsp_viol),
    .rsp_route(rsp_route)
);

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [47:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_viol, rsp_route;
    logic [3:0]  rsp_target;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_secure(req_secure),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_viol(rsp_viol),
        .rsp_route(rsp_route), .rsp_target(rsp_target)
    );

    // {addr[47:0], write, secure, hit, viol, route, target[3:0]}
    localparam int NV = 14;
    localparam logic [56:0] VEC [NV] = '{
        {48'h0000_0080_0000, 2'b00, 3'b101, 4'h3}, // R7 overlap -> W1
        {48'h0000_0100_0000, 2'b00, 3'b101, 4'h5}, // W2 only
        {48'h0000_0200_0000, 2'b00, 3'b101, 4'h5}, // R4 W2 high granule
        {48'h0000_0210_0000, 2'b00, 3'b001, 4'h9}, // R4 above W2 -> default
        {48'h0000_00FF_FFFF, 2'b00, 3'b101, 4'h3}, // R4 last byte of W1
        {48'h0000_000F_FFFF, 2'b00, 3'b001, 4'h9}, // below W1 -> default
        {48'h0000_F000_0000, 2'b00, 3'b101, 4'hE}, // config window
        {48'h0000_F0FF_FFFF, 2'b00, 3'b101, 4'hE}, // config last byte
        {48'h0000_F100_0000, 2'b00, 3'b001, 4'h9}, // above config
        {48'h8000_0010_0000, 2'b00, 3'b001, 4'h9}, // high bit only
        {48'h0000_1000_0000, 2'b10, 3'b110, 4'h0}, // R10 blocked write
        {48'h0000_1000_0000, 2'b11, 3'b101, 4'h7}, // secure write ok
        {48'h0000_1000_0000, 2'b00, 3'b101, 4'h7}, // non-secure read ok
        {48'h0000_1010_0000, 2'b10, 3'b001, 4'h9}  // miss, no violation
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        check(tag, reg_rdata, exp);
    endtask

    task automatic req(input logic [47:0] a, input logic w, input logic s,
                       input logic [2:0] exp_hvr, input logic [3:0] exp_t,
                       input string tag);
        req_valid = 1'b1; req_addr = a; req_write = w; req_secure = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
        check(tag, {rsp_valid, rsp_hit, rsp_viol, rsp_route, rsp_target},
                   {1'b1, exp_hvr, exp_t});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 idle outputs", {rsp_valid, rsp_hit, rsp_viol, rsp_route}, 4'b0);
        rd(9'h000, 32'h0000_0E01, "R1 W0 ctrl");
        rd(9'h008, 32'h0000_F000, "R1 W0 low");
        rd(9'h00C, 32'h0000_F0F0, "R1 W0 high");
        rd(9'h010, 32'h0, "R1 W1 ctrl");
        rd(9'h100, 32'h0, "R1 default");
        req(48'h0000_F080_0000, 1'b0, 1'b0, 3'b101, 4'hE, "R1 config hit");
        req(48'h0000_0080_0000, 1'b0, 1'b0, 3'b001, 4'h0, "R6 reset default");

        // Program windows (R5, R9, R11 layout)
        wr(9'h018, 32'h0000_001F);
        wr(9'h01C, 32'h0000_00F0);
        wr(9'h010, 32'h0000_0301);
        wr(9'h028, 32'h0000_0080);
        wr(9'h02C, 32'h0000_0200);
        wr(9'h020, 32'h0000_0501);
        wr(9'h034, 32'h0000_0002);
        wr(9'h038, 32'h0000_1000);
        wr(9'h03C, 32'h0000_1000);
        wr(9'h030, 32'h0000_0701);
        wr(9'h100, 32'h0000_0009);
        // R11: request right after the default write sees it
        req(48'h0000_0210_0000, 1'b0, 1'b0, 3'b001, 4'h9, "R11 write then request");

        // Vector table (R4/R5/R6/R7/R10)
        for (int i = 0; i < NV; i++) begin
            logic [56:0] v;
            v = VEC[i];
            req(v[56:9], v[8], v[7], v[6:4], v[3:0], $sformatf("R4/R5/R6/R7/R10 vector %0d", i));
        end

        // R3 low nibble dropped, fields in [31:4]
        rd(9'h018, 32'h0000_0010, "R3 W1 low nibble");
        rd(9'h01C, 32'h0000_00F0, "R3 W1 high");
        rd(9'h010, 32'h0000_0301, "R5 W1 ctrl");

        // R9 independent security bits
        rd(9'h034, 32'h0000_0002, "R9 W3 sec");
        wr(9'h034, 32'h0000_0003);
        rd(9'h034, 32'h0000_0003, "R9 both bits");
        req(48'h0000_1000_0000, 1'b1, 1'b0, 3'b110, 4'h0, "R10 still blocked");
        wr(9'h034, 32'h0000_0001);
        rd(9'h034, 32'h0000_0001, "R9 read-secure only");
        req(48'h0000_1000_0000, 1'b1, 1'b0, 3'b101, 4'h7, "R10 unprotected write");

        // R8 disable keeps fields, re-enable restores
        wr(9'h010, 32'h0000_0300);
        req(48'h0000_0080_0000, 1'b0, 1'b0, 3'b101, 4'h5, "R8 W1 off, W2 takes");
        req(48'h0000_0010_0000, 1'b0, 1'b0, 3'b001, 4'h9, "R8 W1 off, default");
        rd(9'h010, 32'h0000_0300, "R8 ctrl kept");
        rd(9'h018, 32'h0000_0010, "R8 low kept");
        wr(9'h010, 32'h0000_0301);
        req(48'h0000_0080_0000, 1'b0, 1'b0, 3'b101, 4'h3, "R8 restored");

        // R12 unmapped offsets
        rd(9'h0F0, 32'h0, "R12 beyond windows");
        rd(9'h104, 32'h0, "R12 beyond default");
        wr(9'h0F8, 32'hFFFF_FFF0);
        rd(9'h078, 32'h0, "R12 no alias into W7");
        check("R2 idle after requests", {rsp_valid, rsp_hit, rsp_viol, rsp_route}, 4'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule